// File: doc/BRIEF.md
# Multi-Format Page Table Walker

This block translates a virtual address into a physical address by walking page tables held in memory. A request carries the virtual address and three access flags (write, user, execute). Mode inputs select one of three table formats: a two-level format with 32-bit entries, a three-level format with 64-bit entries, and a four-level format with 64-bit entries. A fourth setting turns translation off, so that the address passes straight through. The root table address comes from a root register input.

The walker reads one entry per level through a memory read port. That port uses a valid/ready request and allows one read in flight. Read data comes back on a separate response strobe. The walk ends early on a large-page entry, on an entry that is not present, or on an entry whose permission bits refuse the access. A single-cycle `done` pulse then reports either the physical address or a fault with an error code.

Top module: `pgwalk_top`

## Requirements
- R1: After reset, `req_ready` is 1, and `done` and `mem_rd_valid` are both 0.
- R2: With `cfg_paging` = 0, the walker makes no memory reads. `done` pulses in the cycle after the request is accepted, with `done_fault` = 0 and `done_paddr` equal to the virtual address.
- R3: A walk with no early exit makes 2 reads in the 32-bit format (`cfg_pae` = 0), 4 reads when `cfg_pae` and `cfg_long` are both 1, and 3 reads when `cfg_pae` = 1 and `cfg_long` = 0.
- R4: For the read at level L (L counts down from the top level to 1), the index is the virtual address shifted right by 12 + s·(L−1), keeping s bits. s is 10 in the 32-bit format and 9 in the others. The read address is the table base plus the index times the entry size. The entry size is 4 bytes in the 32-bit format and 8 bytes in the others. `mem_rd_wide` is 1 exactly for 8-byte reads. The 32-bit format uses only bits 31:0 of `mem_rsp_data`.
- R5: The top-level base is derived from `cfg_root` as follows. In the 32-bit format it is root bits 31:12. In the four-level format it is root bits 51:12. In the three-level format it is the root with bits 4:0 cleared and no other masking. Each lower table base is the entry's bits 51:12 for 8-byte entries, and bits 31:12 for 4-byte entries.
- R6: An entry with bit 0 (present) clear ends the walk with a fault.
- R7: In the three-level format, the top-level entry is checked only for presence. Its permission bits are ignored.
- R8: An entry at level-index 1 (the one that points at the last table) with bit 7 set ends the walk as a large page. With 8-byte entries the address is {entry[51:21], va[20:0]}. In the 32-bit format it is {entry[20:13], entry[31:22], va[21:0]}.
- R9: An access faults on these conditions. A write faults when `cfg_wp` = 1 and entry bit 1 is clear. A user access faults when entry bit 2 is clear. An execute access faults when entry bit 63 is set, but only in the 8-byte formats. These checks apply to every entry visited except the one excluded by R7.
- R10: On a fault, `done_err` bit 1 equals the write flag, bit 2 the user flag and bit 4 the execute flag. Bit 0 is 1 only when the refusing entry is the last-level entry or a large-page entry and that entry is present. Bit 3 is 0. On success, `done_err` is 0.
- R11: A walk that reaches the last-level entry returns {frame base[63:12], va[11:0]}.
- R12: A request is accepted only when `req_ready` is 1, which means the walker is idle and not pulsing `done`. `done` lasts one cycle. `mem_rd_valid` and `mem_rd_addr` stay stable until `mem_rd_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker can accept a request |
| req_vaddr | input | 64 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user level |
| req_exec | input | 1 | Access is an instruction fetch |
| cfg_paging | input | 1 | Translation enabled |
| cfg_pae | input | 1 | Selects 8-byte entry formats |
| cfg_long | input | 1 | Selects the four-level format when `cfg_pae` is 1 |
| cfg_wp | input | 1 | Enforce the write bit |
| cfg_root | input | 64 | Root table register |
| mem_rd_valid | output | 1 | Entry read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 64 | Entry byte address |
| mem_rd_wide | output | 1 | 1 for an 8-byte read, 0 for a 4-byte read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data, little-endian from the entry address |
| done | output | 1 | One-cycle completion pulse |
| done_fault | output | 1 | Translation faulted |
| done_paddr | output | 64 | Physical address on success |
| done_err | output | 5 | Fault error code |

## Verification
The bench targets several corner cases, each with a known wrong outcome. It uses a top-level table base that is 32-byte aligned but not 4 KB aligned; a walker that masks it to a page would read an empty slot and fault. It places 32-bit entries next to one another, so that a walker using the upper half of the 64-bit response gets a neighbour's value. It sets write, user and no-execute restrictions on non-leaf entries, on leaf entries and on the presence-only top entry, and sweeps every flag combination with the write-protect control both set and clear. A walker that checks the top entry's permissions, enforces writes without write protect, or honours no-execute in the 32-bit format then returns the wrong fault or error code. It also covers large pages of both sizes, with bits above bit 51 set in the entries, so that a wrong field placement or a missing mask shows up in the returned address.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

    localparam int VA_W       = 64;
    localparam int PHYS_TOP   = 51;
    localparam int PAGE_SHIFT = 12;
    localparam int ERR_W      = 5;

    // entry bit positions
    localparam int EB_PRES  = 0;
    localparam int EB_WRITE = 1;
    localparam int EB_USER  = 2;
    localparam int EB_SIZE  = 7;
    localparam int EB_NOEX  = 63;

    typedef enum logic [1:0] {
        FMT_FLAT,
        FMT_LEG2,
        FMT_PAE3,
        FMT_LONG4
    } fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT
    } st_e;

    typedef struct packed {
        logic wr;
        logic usr;
        logic exe;
    } acc_t;

    function automatic fmt_e pick_fmt(input logic pg, input logic pae, input logic lm);
        if (!pg)       return FMT_FLAT;
        else if (!pae) return FMT_LEG2;
        else if (lm)   return FMT_LONG4;
        else           return FMT_PAE3;
    endfunction

    function automatic logic [2:0] top_level(input fmt_e f);
        case (f)
            FMT_LEG2:  return 3'd2;
            FMT_PAE3:  return 3'd3;
            FMT_LONG4: return 3'd4;
            default:   return 3'd0;
        endcase
    endfunction

    function automatic logic [VA_W-1:0] frame_of(input logic [VA_W-1:0] e);
        logic [VA_W-1:0] m;
        m = '0;
        m[PHYS_TOP:PAGE_SHIFT] = '1;
        return e & m;
    endfunction

    function automatic logic [VA_W-1:0] root_base(input fmt_e f, input logic [VA_W-1:0] r);
        case (f)
            FMT_LEG2:  return {32'b0, r[31:12], 12'b0};
            FMT_PAE3:  return {r[VA_W-1:5], 5'b0};
            default:   return frame_of(r);
        endcase
    endfunction

    function automatic logic [ERR_W-1:0] mk_err(input acc_t a, input logic pbit);
        return {a.exe, 1'b0, a.usr, a.wr, pbit};
    endfunction

endpackage

// File: rtl/pgwalk_addr.sv
module pgwalk_addr
    import pgwalk_pkg::*;
#(
    parameter int LEG_IDX_W  = 10,
    parameter int WIDE_IDX_W = 9
) (
    input  fmt_e            fmt,
    input  logic [2:0]      lvl,
    input  logic [VA_W-1:0] base,
    input  logic [VA_W-1:0] vaddr,
    input  logic [VA_W-1:0] entry,
    output logic            wide,
    output logic [VA_W-1:0] rd_addr,
    output logic [VA_W-1:0] next_base,
    output logic [VA_W-1:0] leaf_pa,
    output logic [VA_W-1:0] large_pa
);
    localparam int IDX_MAX = (LEG_IDX_W > WIDE_IDX_W) ? LEG_IDX_W : WIDE_IDX_W;

    logic [2:0]         lvl_m1;
    logic [6:0]         shamt;
    logic [IDX_MAX-1:0] idx;
    logic [IDX_MAX-1:0] idx_mask;

    assign wide   = (fmt == FMT_PAE3) || (fmt == FMT_LONG4);
    assign lvl_m1 = lvl - 3'd1;

    always_comb begin
        idx_mask = wide ? IDX_MAX'((1 << WIDE_IDX_W) - 1) : IDX_MAX'((1 << LEG_IDX_W) - 1);
        shamt    = 7'(PAGE_SHIFT) + 7'(lvl_m1) * (wide ? 7'(WIDE_IDX_W) : 7'(LEG_IDX_W));
        idx      = IDX_MAX'(vaddr >> shamt) & idx_mask;
        if (wide)
            rd_addr = base + {{(VA_W-IDX_MAX-3){1'b0}}, idx, 3'b0};
        else
            rd_addr = base + {{(VA_W-IDX_MAX-2){1'b0}}, idx, 2'b0};
    end

    always_comb begin
        next_base = wide ? frame_of(entry) : {32'b0, entry[31:12], 12'b0};
        leaf_pa   = {next_base[VA_W-1:PAGE_SHIFT], vaddr[PAGE_SHIFT-1:0]};
        if (wide)
            large_pa = {{(VA_W-PHYS_TOP-1){1'b0}}, entry[PHYS_TOP:21], vaddr[20:0]};
        else
            large_pa = {24'b0, entry[20:13], entry[31:22], vaddr[21:0]};
    end

endmodule

// File: rtl/pgwalk_perm.sv
module pgwalk_perm
    import pgwalk_pkg::*;
(
    input  logic [VA_W-1:0] entry,
    input  fmt_e            fmt,
    input  logic [2:0]      tlvl,
    input  acc_t            acc,
    input  logic            wp,
    output logic            present,
    output logic            is_large,
    output logic            perm_ok,
    output logic            pbit
);
    logic skip, w_bad, u_bad, x_bad;

    always_comb begin
        present  = entry[EB_PRES];
        skip     = (fmt == FMT_PAE3) && (tlvl == 3'd2);
        is_large = (tlvl == 3'd1) && entry[EB_SIZE];
        pbit     = present && ((tlvl == 3'd0) || is_large);
        w_bad    = wp && acc.wr && !entry[EB_WRITE];
        u_bad    = acc.usr && !entry[EB_USER];
        x_bad    = (fmt != FMT_LEG2) && acc.exe && entry[EB_NOEX];
        perm_ok  = skip || !(w_bad || u_bad || x_bad);
    end

endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
    import pgwalk_pkg::*;
#(
    parameter int LEG_IDX_W  = 10,
    parameter int WIDE_IDX_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [63:0]      req_vaddr,
    input  logic             req_write,
    input  logic             req_user,
    input  logic             req_exec,
    input  logic             cfg_paging,
    input  logic             cfg_pae,
    input  logic             cfg_long,
    input  logic             cfg_wp,
    input  logic [63:0]      cfg_root,
    output logic             mem_rd_valid,
    input  logic             mem_rd_ready,
    output logic [63:0]      mem_rd_addr,
    output logic             mem_rd_wide,
    input  logic             mem_rsp_valid,
    input  logic [63:0]      mem_rsp_data,
    output logic             done,
    output logic             done_fault,
    output logic [63:0]      done_paddr,
    output logic [4:0]       done_err
);
    st_e             state_q;
    fmt_e            fmt_q, fmt_in;
    acc_t            acc_q;
    logic            wp_q;
    logic [VA_W-1:0] va_q, base_q, pa_q;
    logic [2:0]      lvl_q, tlvl;
    logic            done_q, fault_q;
    logic [ERR_W-1:0] err_q;

    logic [VA_W-1:0] entry, rd_addr, next_base, leaf_pa, large_pa;
    logic            wide, present, is_large, perm_ok, pbit;

    assign fmt_in = pick_fmt(cfg_paging, cfg_pae, cfg_long);
    assign entry  = wide ? mem_rsp_data : {32'b0, mem_rsp_data[31:0]};
    assign tlvl   = lvl_q - 3'd1;

    pgwalk_addr #(
        .LEG_IDX_W (LEG_IDX_W),
        .WIDE_IDX_W(WIDE_IDX_W)
    ) u_addr (
        .fmt      (fmt_q),
        .lvl      (lvl_q),
        .base     (base_q),
        .vaddr    (va_q),
        .entry    (entry),
        .wide     (wide),
        .rd_addr  (rd_addr),
        .next_base(next_base),
        .leaf_pa  (leaf_pa),
        .large_pa (large_pa)
    );

    pgwalk_perm u_perm (
        .entry   (entry),
        .fmt     (fmt_q),
        .tlvl    (tlvl),
        .acc     (acc_q),
        .wp      (wp_q),
        .present (present),
        .is_large(is_large),
        .perm_ok (perm_ok),
        .pbit    (pbit)
    );

    assign req_ready    = (state_q == ST_IDLE) && !done_q;
    assign mem_rd_valid = (state_q == ST_ISSUE);
    assign mem_rd_addr  = rd_addr;
    assign mem_rd_wide  = wide;
    assign done         = done_q;
    assign done_fault   = fault_q;
    assign done_paddr   = pa_q;
    assign done_err     = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            fmt_q   <= FMT_FLAT;
            acc_q   <= '0;
            wp_q    <= 1'b0;
            va_q    <= '0;
            base_q  <= '0;
            lvl_q   <= '0;
            done_q  <= 1'b0;
            fault_q <= 1'b0;
            pa_q    <= '0;
            err_q   <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid && req_ready) begin
                        fmt_q <= fmt_in;
                        acc_q <= '{wr: req_write, usr: req_user, exe: req_exec};
                        wp_q  <= cfg_wp;
                        va_q  <= req_vaddr;
                        if (fmt_in == FMT_FLAT) begin
                            done_q  <= 1'b1;
                            fault_q <= 1'b0;
                            err_q   <= '0;
                            pa_q    <= req_vaddr;
                        end else begin
                            base_q  <= root_base(fmt_in, cfg_root);
                            lvl_q   <= top_level(fmt_in);
                            state_q <= ST_ISSUE;
                        end
                    end
                end
                ST_ISSUE: begin
                    if (mem_rd_ready) state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (!present || !perm_ok) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                            fault_q <= 1'b1;
                            err_q   <= mk_err(acc_q, pbit);
                        end else if (tlvl == 3'd0) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                            fault_q <= 1'b0;
                            err_q   <= '0;
                            pa_q    <= leaf_pa;
                        end else if (is_large) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                            fault_q <= 1'b0;
                            err_q   <= '0;
                            pa_q    <= large_pa;
                        end else begin
                            base_q  <= next_base;
                            lvl_q   <= tlvl;
                            state_q <= ST_ISSUE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pgwalk_props.sv
module pgwalk_props (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic        req_write,
    input logic        req_user,
    input logic        req_exec,
    input logic        cfg_paging,
    input logic        mem_rd_valid,
    input logic        mem_rd_ready,
    input logic [63:0] mem_rd_addr,
    input logic        done,
    input logic        done_fault,
    input logic [4:0]  done_err
);
    logic cap_w, cap_u, cap_x, cap_flat;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_w    <= 1'b0;
            cap_u    <= 1'b0;
            cap_x    <= 1'b0;
            cap_flat <= 1'b0;
        end else if (req_valid && req_ready) begin
            cap_w    <= req_write;
            cap_u    <= req_user;
            cap_x    <= req_exec;
            cap_flat <= !cfg_paging;
        end
    end

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_hold_read_r12: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    p_busy_after_accept_r12: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && cfg_paging) |=> !req_ready);

    p_flat_noread_r2: assert property (@(posedge clk) disable iff (rst)
        cap_flat |-> !mem_rd_valid);

    p_flat_nofault_r2: assert property (@(posedge clk) disable iff (rst)
        (done && cap_flat) |-> !done_fault);

    p_ok_err_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (done && !done_fault) |-> (done_err == 5'd0));

    p_fault_flags_r10: assert property (@(posedge clk) disable iff (rst)
        (done && done_fault) |-> (done_err[1] == cap_w && done_err[2] == cap_u &&
                                  done_err[4] == cap_x && !done_err[3]));

endmodule

bind pgwalk_top pgwalk_props u_pgwalk_props (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .req_user    (req_user),
    .req_exec    (req_exec),
    .cfg_paging  (cfg_paging),
    .mem_rd_valid(mem_rd_valid),
    .mem_rd_ready(mem_rd_ready),
    .mem_rd_addr (mem_rd_addr),
    .done        (done),
    .done_fault  (done_fault),
    .done_err    (done_err)
);

// File: tb/test_pgwalk_top.sv
`timescale 1ns/1ps
module test_pgwalk_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_vaddr = '0;
    logic        req_write = 1'b0, req_user = 1'b0, req_exec = 1'b0;
    logic        cfg_paging = 1'b0, cfg_pae = 1'b0, cfg_long = 1'b0, cfg_wp = 1'b0;
    logic [63:0] cfg_root = '0;
    logic        mem_rd_valid;
    logic        mem_rd_ready;
    logic [63:0] mem_rd_addr;
    logic        mem_rd_wide;
    logic        mem_rsp_valid;
    logic [63:0] mem_rsp_data;
    logic        done, done_fault;
    logic [63:0] done_paddr;
    logic [4:0]  done_err;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    pgwalk_top i_pgwalk_top (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_user(req_user), .req_exec(req_exec),
        .cfg_paging(cfg_paging), .cfg_pae(cfg_pae), .cfg_long(cfg_long),
        .cfg_wp(cfg_wp), .cfg_root(cfg_root),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
        .mem_rd_addr(mem_rd_addr), .mem_rd_wide(mem_rd_wide),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done(done), .done_fault(done_fault), .done_paddr(done_paddr), .done_err(done_err)
    );

    // sparse byte memory
    logic [7:0]  mem [logic [63:0]];
    logic [63:0] act_a [int];
    logic        act_w [int];
    int          rd_count = 0;
    logic [1:0]  tick, dly;
    logic [63:0] pend_a;
    logic [63:0] exp_a [0:3];

    function automatic logic [63:0] rd64(input logic [63:0] a);
        logic [63:0] v;
        v = '0;
        for (int i = 0; i < 8; i++)
            if (mem.exists(a + 64'(i))) v[i*8 +: 8] = mem[a + 64'(i)];
        return v;
    endfunction

    task automatic put64(input logic [63:0] a, input logic [63:0] v);
        for (int i = 0; i < 8; i++) mem[a + 64'(i)] = v[i*8 +: 8];
    endtask

    task automatic put32(input logic [63:0] a, input logic [31:0] v);
        for (int i = 0; i < 4; i++) mem[a + 64'(i)] = v[i*8 +: 8];
    endtask

    // memory responder: ready stalls one cycle in four, data two cycles after accept
    always @(posedge clk) begin
        if (rst) begin
            tick          <= '0;
            dly           <= '0;
            pend_a        <= '0;
            mem_rd_ready  <= 1'b0;
            mem_rsp_valid <= 1'b0;
            mem_rsp_data  <= '0;
        end else begin
            tick          <= tick + 2'd1;
            mem_rd_ready  <= (tick != 2'd1);
            mem_rsp_valid <= 1'b0;
            if (mem_rd_valid && mem_rd_ready) begin
                act_a[rd_count] = mem_rd_addr;
                act_w[rd_count] = mem_rd_wide;
                rd_count        = rd_count + 1;
                pend_a <= mem_rd_addr;
                dly    <= 2'd2;
            end else if (dly != 2'd0) begin
                dly <= dly - 2'd1;
                if (dly == 2'd1) begin
                    mem_rsp_valid <= 1'b1;
                    mem_rsp_data  <= rd64(pend_a);
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // behavioural model built from the requirements
    task automatic model(input logic [63:0] va, input logic w, u, x, pg, pae, lm, wp,
                         input logic [63:0] cr, output logic f, output logic [63:0] pa,
                         output logic [4:0] err, output int n, output string tag);
        int lv, sh;
        logic [63:0] base, e, idx, nb;
        logic lg, pb, r7;
        f = 0; pa = '0; err = '0; n = 0; tag = "R2"; r7 = 0;
        if (!pg) begin pa = va; return; end
        lv = !pae ? 2 : (lm ? 4 : 3);
        base = !pae ? (cr & 64'hFFFF_F000) : (lm ? (cr & 64'h000F_FFFF_FFFF_F000) : (cr & ~64'h1F));
        for (int L = lv; L >= 1; L--) begin
            sh  = pae ? 9 : 10;
            idx = (va >> (12 + sh * (L - 1))) & ((64'd1 << sh) - 64'd1);
            exp_a[n] = base + idx * (pae ? 64'd8 : 64'd4);
            e = rd64(exp_a[n]);
            if (!pae) e = e & 64'hFFFF_FFFF;
            n++;
            if (!e[0]) begin
                f = 1; err = {x, 1'b0, u, w, 1'b0}; tag = r7 ? "R6+R7" : "R6"; return;
            end
            if (pae && !lm && L - 1 == 2) begin
                if ((wp && w && !e[1]) || (u && !e[2]) || (x && e[63])) r7 = 1;
                base = e & 64'h000F_FFFF_FFFF_F000;
                continue;
            end
            lg = (L - 1 == 1) && e[7];
            pb = (L - 1 == 0) || lg;
            if ((wp && w && !e[1]) || (u && !e[2]) || (pae && x && e[63])) begin
                f = 1; err = {x, 1'b0, u, w, pb}; tag = r7 ? "R9+R7" : "R9"; return;
            end
            nb = pae ? (e & 64'h000F_FFFF_FFFF_F000) : (e & 64'hFFFF_F000);
            if (L - 1 == 0) begin
                pa = {nb[63:12], va[11:0]}; tag = r7 ? "R11+R7" : "R11"; return;
            end
            if (lg) begin
                if (pae) pa = (e & 64'h000F_FFFF_FFE0_0000) | (va & 64'h1F_FFFF);
                else     pa = ((e & 64'h1F_E000) << 19) | (e & 64'hFFC0_0000) | (va & 64'h3F_FFFF);
                tag = r7 ? "R8+R7" : "R8"; return;
            end
            base = nb;
        end
    endtask

    task automatic run(input logic [63:0] va, input logic w, u, x, pg, pae, lm, wp,
                       input logic [63:0] cr);
        logic ef; logic [63:0] epa; logic [4:0] eerr; int en; string tag;
        int start, cyc; bit busy_bad;
        model(va, w, u, x, pg, pae, lm, wp, cr, ef, epa, eerr, en, tag);
        @(negedge clk);
        start = rd_count;
        req_vaddr = va; req_write = w; req_user = u; req_exec = x;
        cfg_paging = pg; cfg_pae = pae; cfg_long = lm; cfg_wp = wp; cfg_root = cr;
        req_valid = 1'b1;
        chk(req_ready == 1'b1, "R12", "ready when idle", 64'(req_ready), 64'd1);
        @(negedge clk);
        req_valid = 1'b0;
        busy_bad = 0; cyc = 0;
        while (!done && cyc < 200) begin
            if (req_ready) busy_bad = 1;
            @(negedge clk);
            cyc++;
        end
        if (cyc >= 200) begin
            chk(1'b0, "R12", "walk timeout", 64'(cyc), 64'd0);
            return;
        end
        if (!pg) chk(cyc == 0, "R2", "flat latency", 64'(cyc), 64'd0);
        chk(!busy_bad, "R12", "ready low while busy", 64'(busy_bad), 64'd0);
        chk(done_fault == ef, tag, "fault", 64'(done_fault), 64'(ef));
        if (!ef) chk(done_paddr == epa, tag, "paddr", done_paddr, epa);
        chk(done_err == eerr, "R10", "err code", 64'(done_err), 64'(eerr));
        chk(rd_count - start == en, pg ? "R3" : "R2", "read count", 64'(rd_count - start), 64'(en));
        for (int i = 0; i < en && i < rd_count - start; i++) begin
            chk(act_a[start + i] == exp_a[i], i == 0 ? "R5" : "R4", "entry address",
                act_a[start + i], exp_a[i]);
            chk(act_w[start + i] == pae, "R4", "read width", 64'(act_w[start + i]), 64'(pae));
        end
        @(negedge clk);
        chk(done == 1'b0, "R12", "done single pulse", 64'(done), 64'd0);
    endtask

    localparam logic [63:0] LEG_ROOT  = 64'h0000_0001_0000_1ABC;
    localparam logic [63:0] PAE_ROOT  = 64'h0000_0000_0000_5027;
    localparam logic [63:0] LONG_ROOT = 64'hFFF0_0000_0000_9FFF;

    logic [63:0] leg_va [0:6] = '{64'h0000_1ABC, 64'h0000_2123, 64'h0000_3FFF,
                                  64'h0040_0000, 64'h0083_4567, 64'h00C0_1234, 64'h0100_0008};
    logic [63:0] pae_va [0:7] = '{64'h0000_0123, 64'h0000_1456, 64'h0000_2789, 64'h0000_3000,
                                  64'h0020_1234, 64'h0040_0000, 64'h0060_0010, 64'h4000_0000};
    logic [63:0] lng_va [0:8] = '{64'h0, 64'h1ABC, 64'h2000, 64'h3000, 64'h0020_0001,
                                  64'h0040_0000, 64'h4000_0000, 64'h0000_0080_0000_0123,
                                  64'h0000_0100_0000_0000};

    initial begin
        // two-level tables, 4-byte entries
        put32(64'h1000, 32'h0000_2007);
        put32(64'h1004, 32'h0000_0000);
        put32(64'h1008, 32'h00C0_A087);
        put32(64'h100C, 32'h0100_0081);
        put32(64'h1010, 32'h0000_3001);
        put32(64'h2004, 32'h0005_5007);
        put32(64'h2008, 32'h0006_6001);
        put32(64'h200C, 32'h0000_0000);
        put32(64'h3000, 32'h0000_7007);
        // three-level tables
        put64(64'h5020, 64'h8000_0000_0000_6001);
        put64(64'h6000, 64'h0000_0000_0000_7007);
        put64(64'h6008, 64'h8080_000A_0020_0087);
        put64(64'h6018, 64'h0000_0000_0000_8005);
        put64(64'h7000, 64'h1000_0001_2345_6007);
        put64(64'h7008, 64'h8000_0000_0000_9007);
        put64(64'h7010, 64'h0000_0000_000A_A003);
        put64(64'h8000, 64'h0000_0000_0000_B007);
        // four-level tables
        put64(64'h9000, 64'h0000_0000_0000_A007);
        put64(64'h9008, 64'h0000_0000_0000_F003);
        put64(64'hA000, 64'h0000_0000_0000_B007);
        put64(64'hF000, 64'h0000_0000_0000_B007);
        put64(64'hB000, 64'h0000_0000_0000_C007);
        put64(64'hB008, 64'h8000_0034_5660_0087);
        put64(64'hC000, 64'h0000_0000_0000_D007);
        put64(64'hC008, 64'h8000_0000_0000_E007);
        put64(64'hC010, 64'h0000_0000_0011_1005);

        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "reset req_ready", 64'(req_ready), 64'd1);
        chk(done == 1'b0, "R1", "reset done", 64'(done), 64'd0);
        chk(mem_rd_valid == 1'b0, "R1", "reset mem_rd_valid", 64'(mem_rd_valid), 64'd0);

        run(64'h1234_5678_9ABC_DEF0, 1, 1, 1, 0, 1, 1, 1, LONG_ROOT);
        run(64'h0000_0000_0000_0FFF, 0, 0, 0, 0, 0, 0, 0, LEG_ROOT);

        foreach (leg_va[i])
            for (int f = 0; f < 8; f++)
                for (int wp = 0; wp < 2; wp++)
                    run(leg_va[i], f[0], f[1], f[2], 1, 0, 0, wp[0], LEG_ROOT);
        foreach (pae_va[i])
            for (int f = 0; f < 8; f++)
                for (int wp = 0; wp < 2; wp++)
                    run(pae_va[i], f[0], f[1], f[2], 1, 1, 0, wp[0], PAE_ROOT);
        foreach (lng_va[i])
            for (int f = 0; f < 8; f++)
                for (int wp = 0; wp < 2; wp++)
                    run(lng_va[i], f[0], f[1], f[2], 1, 1, 1, wp[0], LONG_ROOT);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R12 watchdog expired: actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule